// File: doc/BRIEF.md
# Bit-Addressable Register Bank with Demultiplexer Modes

This block holds eight stored bits, each with its own output, and updates them from a single data input. A three-bit address picks one bit position. Two active-low controls, a write enable and a clear, together choose one of four modes:

- **Write** sets the addressed bit from the data input.
- **Hold** freezes all bits.
- **Demultiplexer** routes the data input to the addressed output and drives every other output low.
- **Clear** drives every output low.

All inputs are sampled on the rising edge of a system clock, and the outputs are registered. An active-low system reset zeroes the bank.

A typical use is serial-to-parallel assembly. Software or a sequencer stays in write mode and steps the address while presenting one data bit per clock. The eight outputs then show the assembled byte at once. The same bank can also act as a registered 3-to-8 decoder, by holding the data input high in demultiplexer mode.

Top module: `addr_bit_bank`

## Requirements
- R1: While `rst_n` is low, all eight bits of `q` read 0 after the next rising clock edge, and they stay 0 until `rst_n` is released.
- R2: With `wr_en_n`=0 and `clr_n`=1 (write mode), bit `q[addr]` equals the sampled `din` after the rising edge.
- R3: In write mode, every bit of `q` other than `q[addr]` keeps its previous value.
- R4: With `wr_en_n`=1 and `clr_n`=1 (hold mode), `q` keeps its previous value whatever `din` and `addr` are.
- R5: With `wr_en_n`=0 and `clr_n`=0 (demultiplexer mode), after the edge `q[addr]` equals `din` and every other bit of `q` is 0.
- R6: Demultiplexer mode also replaces the stored contents. After a return to hold mode, only the last addressed bit can read 1.
- R7: With `wr_en_n`=1 and `clr_n`=0 (clear mode), `q` is all zeros after the edge, whatever `din` and `addr` are.
- R8: In write mode, stepping `addr` through positions 0 to 7 with one `din` bit per cycle leaves `q` equal to the assembled byte, with the bit written at address k in `q[k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Active-low system reset, zeroes all bits |
| wr_en_n | input | 1 | Active-low write enable (mode select) |
| clr_n | input | 1 | Active-low clear (mode select) |
| addr | input | 3 | Bit position 0 to 7 |
| din | input | 1 | Serial data input |
| q | output | 8 | Parallel stored or decoded outputs |

## Verification
The bench loads the bank with a spread of 32 byte patterns. From each pattern, it applies every mode with every address and both data values. This separates behaviour that depends on the stored contents (write and hold) from behaviour that overrides them (demultiplexer and clear).

For each step, the bench checks the whole output word against a value it computes arithmetically. A wrong bit select, a leak into unaddressed bits, or a swapped mode encoding therefore each show up as a mismatch.

Two directed sequences cover the remaining cases. The first assembles alternating and all-ones bytes serially. The second follows a demultiplexer step with hold cycles, which separates a demultiplexer mode that clears storage from one that only masks the outputs.

// File: rtl/abb_pkg.sv
package abb_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } abb_mode_e;

endpackage

// File: rtl/abb_mode_decode.sv
module abb_mode_decode
    import abb_pkg::*;
(
    input  logic      wr_en_n,
    input  logic      clr_n,
    output abb_mode_e mode
);
    always_comb begin
        unique case ({clr_n, wr_en_n})
            2'b10:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/abb_addr_decode.sv
module abb_addr_decode #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = $clog2(WIDTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WIDTH-1:0]  sel
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/abb_bit_next.sv
module abb_bit_next
    import abb_pkg::*;
(
    input  abb_mode_e mode,
    input  logic      sel,
    input  logic      din,
    input  logic      cur,
    output logic      nxt
);
    always_comb begin
        unique case (mode)
            MODE_WRITE: nxt = sel ? din : cur;
            MODE_HOLD:  nxt = cur;
            MODE_DEMUX: nxt = sel & din;
            default:    nxt = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_bit_bank.sv
module addr_bit_bank
    import abb_pkg::*;
#(
    parameter  int WIDTH  = 8,
    localparam int ADDR_W = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              din,
    output logic [WIDTH-1:0]  q
);
    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } bank_t;

    bank_t            st_d, st_q;
    abb_mode_e        mode;
    logic [WIDTH-1:0] sel;
    logic [WIDTH-1:0] nxt;

    abb_mode_decode u_mode (
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .mode    (mode)
    );

    abb_addr_decode #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        abb_bit_next u_next (
            .mode (mode),
            .sel  (sel[i]),
            .din  (din),
            .cur  (st_q.bits[i]),
            .nxt  (nxt[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;

    // R2
    write_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=> (q[$past(addr)] == $past(din)));

    // R3
    write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && clr_n) |=>
            (((q ^ $past(q)) & ~(WIDTH'(1) << $past(addr))) == '0));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && clr_n) |=> (q == $past(q)));

    // R5
    demux_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !clr_n) |=>
            (q[$past(addr)] == $past(din)) && ($countones(q) <= 1));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_n && !clr_n) |=> (q == '0));
endmodule

// File: tb/sim_addr_bit_bank.sv
module sim_addr_bit_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic [2:0] addr = '0;
    logic       din = 1'b0;
    logic [7:0] q;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    logic [7:0] model = '0;

    always #2 clk = ~clk;

    addr_bit_bank u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_n (wr_en_n),
        .clr_n   (clr_n),
        .addr    (addr),
        .din     (din),
        .q       (q)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s q=%02h expected %02h", tag, q, exp);
        end
    endtask

    // Encoding: {wr_en_n,clr_n} 01 write, 11 hold, 00 demux, 10 clear.
    function automatic logic [7:0] next_val(input logic [7:0] cur, input logic we_n,
                                            input logic cl_n, input logic [2:0] a,
                                            input logic d);
        logic [7:0] m = 8'(1) << a;
        if (!we_n && cl_n)  return d ? (cur | m) : (cur & ~m);
        if (we_n && cl_n)   return cur;
        if (!we_n && !cl_n) return d ? m : 8'h00;
        return 8'h00;
    endfunction

    task automatic step(input logic we_n, input logic cl_n, input logic [2:0] a,
                        input logic d, input bit do_chk, input string tag);
        @(negedge clk);
        wr_en_n = we_n; clr_n = cl_n; addr = a; din = d;
        model = next_val(model, we_n, cl_n, a, d);
        @(negedge clk);
        if (do_chk) check(tag, model);
    endtask

    task automatic load(input logic [7:0] pat, input bit do_chk, input string tag);
        for (int k = 0; k < 8; k++) step(1'b0, 1'b1, 3'(k), pat[k], 1'b0, "");
        if (do_chk) check(tag, pat);
    endtask

    function automatic string tag_of(input logic we_n, input logic cl_n);
        if (!we_n && cl_n)  return "R2/R3 write";
        if (we_n && cl_n)   return "R4 hold";
        if (!we_n && !cl_n) return "R5 demux";
        return "R7 clear";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        model = 8'h00;
        check("R1 after reset", 8'h00);

        // R8 serial assembly
        load(8'hA5, 1'b1, "R8 serial A5");
        load(8'h5A, 1'b1, "R8 serial 5A");
        load(8'hFF, 1'b1, "R8 serial FF");

        // R6 demux replaces storage, then hold
        step(1'b0, 1'b0, 3'd5, 1'b1, 1'b1, "R6 demux step");
        step(1'b1, 1'b1, 3'd2, 1'b1, 1'b1, "R6 hold after demux");
        step(1'b1, 1'b1, 3'd7, 1'b0, 1'b1, "R6 hold after demux");
        check("R6 only bit5", 8'h20);

        // Sweep: patterns x modes x addresses x data
        for (int p = 0; p < 32; p++) begin
            for (int md = 0; md < 4; md++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int d = 0; d < 2; d++) begin
                        load(8'((p * 37 + 11) % 256), 1'b0, "");
                        step(md[1], md[0], 3'(a), d[0], 1'b1,
                             tag_of(md[1], md[0]));
                    end
                end
            end
        end

        // R1 reset in the middle of operation
        load(8'hC3, 1'b1, "R8 serial C3");
        @(negedge clk);
        rst_n = 1'b0;
        model = 8'h00;
        @(negedge clk);
        check("R1 mid-run reset", 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule